// File: doc/BRIEF.md
# Packet-Filter VM Integer ALU

This block runs the integer arithmetic and logic operations of a packet-filter virtual machine. Each operation takes a 64-bit destination value and a second operand. The second operand is either a 64-bit source register value or a 32-bit immediate. A width-class input selects 32-bit or 64-bit arithmetic. The caller pulses `start_i` with all operands valid. The block returns the new destination value on `result_o` together with a one-cycle `done_o` pulse.

Most operations finish at the clock edge that samples `start_i`. Unsigned division and remainder with a non-zero divisor go through a restoring divider that produces one quotient bit per clock: 32 steps in the 32-bit class and 64 steps in the 64-bit class. While the divider runs, `busy_o` is high and new starts are ignored. No operation traps. Overflow wraps. A zero divisor gives a defined result in a single cycle.

Top module: `pfvm_alu`

## Requirements
- R1: ADD, SUB and MUL wrap modulo 2^32 in the 32-bit class (`wide_i`=0) and modulo 2^64 in the 64-bit class (`wide_i`=1), with no flag. In the 32-bit class only the low 32 bits of each operand take part.
- R2: Every 32-bit-class result has bits 63:32 equal to zero.
- R3: With `use_imm_i`=1 the second operand is `imm_i`. It is zero-extended in the 32-bit class and sign-extended to 64 bits in the 64-bit class, and in both cases it is then used as an unsigned value.
- R4: The shift count is the low 5 bits of the second operand in the 32-bit class and the low 6 bits in the 64-bit class. LSH shifts left. RSH shifts right and fills with zeros. ARSH shifts right and fills with copies of the sign bit of the class width (bit 31 or bit 63).
- R5: NEG returns the two's-complement negation of the destination. MOV returns the second operand. OR, AND and XOR combine the two operands bitwise.
- R6: DIV returns the unsigned quotient of destination over second operand, and MOD returns the unsigned remainder.
- R7: DIV with a zero divisor returns zero and completes at the start edge.
- R8: MOD with a zero divisor returns the destination unchanged (its low 32 bits in the 32-bit class) and completes at the start edge.
- R9: Every operation except DIV or MOD with a non-zero divisor raises `done_o` for exactly one cycle, right after the edge that samples `start_i`. DIV or MOD with a non-zero divisor raises `done_o` 32 edges (32-bit class) or 64 edges (64-bit class) after that edge, and holds `busy_o` high until then.
- R10: A `start_i` pulse that arrives while `busy_o` is high is ignored. Changes on the operand inputs during a division do not affect its result.
- R11: Operation codes on `op_i` are 0 ADD, 1 SUB, 2 MUL, 3 DIV, 4 OR, 5 AND, 6 LSH, 7 RSH, 8 NEG, 9 MOD, 10 XOR, 11 MOV and 12 ARSH. Codes 13, 14 and 15 complete in one cycle with `illegal_o`=1 and a zero result. `illegal_o` is 0 for every other code.
- R12: After reset, `done_o`, `busy_o` and `illegal_o` are 0 and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| use_imm_i | input | 1 | 1 = immediate operand, 0 = source register |
| dst_i | input | 64 | Destination register value |
| src_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate field |
| busy_o | output | 1 | Divider running |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Completed operation had an undefined code |
| result_o | output | 64 | New destination value, held until the next completion |

## Verification
Single-cycle operations and zero-divisor divisions must show `done_o` and their result at the first falling edge after the start edge. A division with a non-zero divisor must show them at the 33rd falling edge (32-bit class) or the 65th (64-bit class). After driving a start, the bench counts falling edges until `done_o` appears and compares that count with the latency its model predicts. It also checks that `done_o` is low one edge later and that `busy_o` is high at the first edge of every long division. For every operation, the result and the illegal flag are compared at the completion edge itself.

// File: rtl/pfvm_alu_pkg.sv
package pfvm_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_DIV  = 4'd3,
        OP_OR   = 4'd4,
        OP_AND  = 4'd5,
        OP_LSH  = 4'd6,
        OP_RSH  = 4'd7,
        OP_NEG  = 4'd8,
        OP_MOD  = 4'd9,
        OP_XOR  = 4'd10,
        OP_MOV  = 4'd11,
        OP_ARSH = 4'd12,
        OP_R13  = 4'd13,
        OP_R14  = 4'd14,
        OP_R15  = 4'd15
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DIV  = 1'b1
    } alu_state_e;

endpackage

// File: rtl/pfvm_operand.sv
module pfvm_operand #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              wide_i,
    input  logic              use_imm_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o,
    output logic              b_zero_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] b_raw;

    // immediate: sign-extended for the wide class, zero-extended otherwise (R3)
    always_comb begin
        if (wide_i) begin
            imm_ext = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        end else begin
            imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_i};
        end
        b_raw = use_imm_i ? imm_ext : src_i;
        if (wide_i) begin
            a_o = dst_i;
            b_o = b_raw;
        end else begin
            a_o = {{HALF_W{1'b0}}, dst_i[HALF_W-1:0]};
            b_o = {{HALF_W{1'b0}}, b_raw[HALF_W-1:0]};
        end
        b_zero_o = (b_o == '0);
    end

endmodule

// File: rtl/pfvm_fastops.sv
module pfvm_fastops
    import pfvm_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  op_e               op_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              illegal_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SH_W   = $clog2(DATA_W);

    logic [SH_W-1:0]          shamt;
    logic signed [DATA_W-1:0] a_signed;
    logic [DATA_W-1:0]        raw;

    always_comb begin
        // count masked to class width (R4)
        shamt = wide_i ? b_i[SH_W-1:0] : {1'b0, b_i[SH_W-2:0]};
        if (wide_i) begin
            a_signed = $signed(a_i);
        end else begin
            a_signed = $signed({{HALF_W{a_i[HALF_W-1]}}, a_i[HALF_W-1:0]});
        end
        illegal_o = 1'b0;
        raw       = '0;
        case (op_i)
            OP_ADD:  raw = a_i + b_i;
            OP_SUB:  raw = a_i - b_i;
            OP_MUL:  raw = a_i * b_i;
            OP_DIV:  raw = '0;          // only reached with zero divisor (R7)
            OP_MOD:  raw = a_i;         // only reached with zero divisor (R8)
            OP_OR:   raw = a_i | b_i;
            OP_AND:  raw = a_i & b_i;
            OP_XOR:  raw = a_i ^ b_i;
            OP_LSH:  raw = a_i << shamt;
            OP_RSH:  raw = a_i >> shamt;
            OP_ARSH: raw = a_signed >>> shamt;
            OP_NEG:  raw = '0 - a_i;
            OP_MOV:  raw = b_i;
            default: illegal_o = 1'b1;
        endcase
        res_o = wide_i ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    end

endmodule

// File: rtl/pfvm_divider.sv
module pfvm_divider #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              half_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    output logic              last_o,
    output logic [DATA_W-1:0] quot_nx_o,
    output logic [DATA_W-1:0] rem_nx_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rem;
        logic [DATA_W-1:0] quo;
        logic [DATA_W-1:0] dvs;
    } div_st_t;

    div_st_t cur_q, nxt_d;
    logic [DATA_W:0] shifted;
    logic [DATA_W:0] diff;
    logic            fits;

    always_comb begin
        shifted   = {cur_q.rem, cur_q.quo[DATA_W-1]};
        diff      = shifted - {1'b0, cur_q.dvs};
        fits      = (shifted >= {1'b0, cur_q.dvs});
        quot_nx_o = {cur_q.quo[DATA_W-2:0], fits};
        rem_nx_o  = fits ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
        last_o    = (cur_q.cnt == CNT_W'(1));

        nxt_d = cur_q;
        if (load_i) begin
            nxt_d.rem = '0;
            nxt_d.dvs = divisor_i;
            if (half_i) begin
                nxt_d.cnt = CNT_W'(HALF_W);
                nxt_d.quo = {dividend_i[HALF_W-1:0], {HALF_W{1'b0}}};
            end else begin
                nxt_d.cnt = CNT_W'(DATA_W);
                nxt_d.quo = dividend_i;
            end
        end else if (cur_q.cnt != '0) begin
            nxt_d.cnt = cur_q.cnt - CNT_W'(1);
            nxt_d.rem = rem_nx_o;
            nxt_d.quo = quot_nx_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.cnt != '0) |-> (cur_q.rem < cur_q.dvs)); // R6
    AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.cnt != '0) |=> (cur_q.cnt == $past(cur_q.cnt) - CNT_W'(1))); // R9
    AST_NO_RELOAD_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.cnt != '0) |-> !load_i); // R10

endmodule

// File: rtl/pfvm_alu.sv
module pfvm_alu
    import pfvm_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic              wide_i,
    input  logic              use_imm_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        alu_state_e        state;
        logic [DATA_W-1:0] result;
        logic              done;
        logic              illegal;
        logic              is_mod;
        logic              wide;
    } alu_st_t;

    alu_st_t st_q, st_d;
    op_e               op;
    logic [DATA_W-1:0] opa, opb;
    logic              opb_zero;
    logic [DATA_W-1:0] fast_res;
    logic              fast_ill;
    logic              is_divmod;
    logic              div_load;
    logic              div_last;
    logic [DATA_W-1:0] div_quo, div_rem;

    assign op        = op_e'(op_i);
    assign is_divmod = (op == OP_DIV) || (op == OP_MOD);

    pfvm_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_operand (
        .wide_i    (wide_i),
        .use_imm_i (use_imm_i),
        .dst_i     (dst_i),
        .src_i     (src_i),
        .imm_i     (imm_i),
        .a_o       (opa),
        .b_o       (opb),
        .b_zero_o  (opb_zero)
    );

    pfvm_fastops #(.DATA_W(DATA_W)) i_fastops (
        .op_i      (op),
        .wide_i    (wide_i),
        .a_i       (opa),
        .b_i       (opb),
        .res_o     (fast_res),
        .illegal_o (fast_ill)
    );

    pfvm_divider #(.DATA_W(DATA_W)) i_divider (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (div_load),
        .half_i     (!wide_i),
        .dividend_i (opa),
        .divisor_i  (opb),
        .last_o     (div_last),
        .quot_nx_o  (div_quo),
        .rem_nx_o   (div_rem)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.illegal = 1'b0;
        div_load     = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.wide = wide_i;
                    if (is_divmod && !opb_zero) begin
                        div_load    = 1'b1;
                        st_d.state  = ST_DIV;
                        st_d.is_mod = (op == OP_MOD);
                    end else begin
                        st_d.result  = fast_res;
                        st_d.done    = 1'b1;
                        st_d.illegal = fast_ill;
                    end
                end
            end
            ST_DIV: begin
                if (div_last) begin
                    st_d.result = st_q.is_mod ? div_rem : div_quo;
                    st_d.done   = 1'b1;
                    st_d.state  = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = (st_q.state == ST_DIV);
    assign done_o    = st_q.done;
    assign illegal_o = st_q.illegal;
    assign result_o  = st_q.result;

    AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !st_q.wide) |-> (st_q.result[DATA_W-1:HALF_W] == '0)); // R2
    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R9
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !div_last) |=> busy_o); // R10
    AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && result_o == '0)); // R11
    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o); // R9

endmodule

// File: tb/test_pfvm_alu.sv
module test_pfvm_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        wide = 1'b1;
    logic        use_imm = 1'b0;
    logic [63:0] dst = '0;
    logic [63:0] src = '0;
    logic [31:0] imm = '0;
    logic        busy_o, done_o, illegal_o;
    logic [63:0] result_o;
    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    pfvm_alu i_pfvm_alu (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .wide_i(wide),
        .use_imm_i(use_imm), .dst_i(dst), .src_i(src), .imm_i(imm),
        .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .result_o(result_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [3:0] o, input logic w, input logic ui,
                                  input logic [63:0] d, input logic [63:0] s, input logic [31:0] im,
                                  output logic [63:0] res, output logic ill, output int lat);
        logic [63:0] a, b;
        logic [5:0]  sh;
        logic signed [31:0] n32;
        logic signed [63:0] n64;
        b = ui ? (w ? {{32{im[31]}}, im} : {32'b0, im}) : s;
        a = d;
        if (!w) begin
            a = {32'b0, d[31:0]};
            b = {32'b0, b[31:0]};
        end
        sh  = w ? b[5:0] : {1'b0, b[4:0]};
        ill = 1'b0;
        lat = 1;
        res = '0;
        case (o)
            4'd0:  res = a + b;
            4'd1:  res = a - b;
            4'd2:  res = a * b;
            4'd3:  begin
                if (b != 0) begin res = a / b; lat = w ? 65 : 33; end
                else res = '0;
            end
            4'd4:  res = a | b;
            4'd5:  res = a & b;
            4'd6:  res = a << sh;
            4'd7:  res = a >> sh;
            4'd8:  res = 64'd0 - a;
            4'd9:  begin
                if (b != 0) begin res = a % b; lat = w ? 65 : 33; end
                else res = a;
            end
            4'd10: res = a ^ b;
            4'd11: res = b;
            4'd12: begin
                if (w) begin n64 = a; n64 = n64 >>> sh; res = n64; end
                else begin n32 = a[31:0]; n32 = n32 >>> sh; res = {32'b0, n32}; end
            end
            default: ill = 1'b1;
        endcase
        if (!w) res = {32'b0, res[31:0]};
    endfunction

    task automatic run_op(input logic [3:0] o, input logic w, input logic ui,
                          input logic [63:0] d, input logic [63:0] s, input logic [31:0] im,
                          input string tag, input bit poke);
        logic [63:0] er;
        logic        ei;
        int          el;
        int          got;
        model(o, w, ui, d, s, im, er, ei, el);
        @(negedge clk);
        op = o; wide = w; use_imm = ui; dst = d; src = s; imm = im; start = 1'b1;
        got = 0;
        for (int c = 1; c <= el + 3 && got == 0; c++) begin
            @(negedge clk);
            if (c == 1) begin
                start = 1'b0;
                if (el > 1) chk(busy_o === 1'b1, {tag, " R9 busy"}, 64'(busy_o), 64'd1);
            end
            if (poke && c == 2) begin start = 1'b1; op = 4'd0; dst = ~d; src = ~s; end
            if (poke && c == 3) start = 1'b0;
            if (done_o === 1'b1) got = c;
        end
        chk(got == el, {tag, " R9 latency"}, 64'(got), 64'(el));
        chk(result_o === er, {tag, " result"}, result_o, er);
        chk(illegal_o === ei, {tag, " R11 illegal"}, 64'(illegal_o), 64'(ei));
        @(negedge clk);
        chk(done_o === 1'b0, {tag, " R9 pulse"}, 64'(done_o), 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] seed_sink;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(done_o === 1'b0, "R12 done", 64'(done_o), 64'd0);
        chk(busy_o === 1'b0, "R12 busy", 64'(busy_o), 64'd0);
        chk(illegal_o === 1'b0, "R12 illegal", 64'(illegal_o), 64'd0);
        chk(result_o === 64'd0, "R12 result", result_o, 64'd0);
        rst_n = 1'b1;

        // R1 wrap
        run_op(4'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, "R1 add64 wrap", 0);
        run_op(4'd0, 0, 0, 64'hABCD_0000_FFFF_FFFF, 64'h1234_0000_0000_0001, 0, "R1 add32 wrap", 0);
        run_op(4'd1, 0, 0, 64'd0, 64'd1, 0, "R1 sub32 underflow", 0);
        run_op(4'd2, 1, 0, 64'h8000_0000_0000_0001, 64'd6, 0, "R1 mul64 overflow", 0);
        // R2 upper half cleared
        run_op(4'd4, 0, 0, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_0000_1234_5678, 0, "R2 or32 upper", 0);
        // R3 immediate extension
        run_op(4'd11, 1, 1, 0, 0, 32'hFFFF_FFFF, "R3 mov64 imm sext", 0);
        run_op(4'd11, 0, 1, 0, 0, 32'hFFFF_FFFF, "R3 mov32 imm zext", 0);
        run_op(4'd3, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'hFFFF_FFFF, "R3 div64 imm unsigned", 0);
        run_op(4'd3, 0, 1, 64'h0000_0000_FFFF_FFFF, 0, 32'hFFFF_FFFF, "R3 div32 imm unsigned", 0);
        // R4 shifts
        run_op(4'd6, 1, 0, 64'd3, 64'd65, 0, "R4 lsh64 mask", 0);
        run_op(4'd6, 0, 0, 64'd3, 64'd33, 0, "R4 lsh32 mask", 0);
        run_op(4'd12, 0, 0, 64'hFFFF_0000_8000_0000, 64'd4, 0, "R4 arsh32 sign", 0);
        run_op(4'd12, 1, 0, 64'h8000_0000_0000_0000, 64'd63, 0, "R4 arsh64 sign", 0);
        run_op(4'd7, 0, 0, 64'hFFFF_FFFF_8000_0000, 64'd31, 0, "R4 rsh32 zero fill", 0);
        // R5 neg, mov, logic
        run_op(4'd8, 0, 0, 64'h7777_0000_0000_0001, 64'd0, 0, "R5 neg32", 0);
        run_op(4'd8, 1, 0, 64'd0, 64'd5, 0, "R5 neg64 zero", 0);
        run_op(4'd5, 1, 0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 0, "R5 and64", 0);
        run_op(4'd10, 1, 0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 0, "R5 xor64", 0);
        // R6 unsigned division
        run_op(4'd3, 1, 0, 64'd100, 64'd7, 0, "R6 div64", 0);
        run_op(4'd9, 1, 0, 64'd100, 64'd7, 0, "R6 mod64", 0);
        run_op(4'd3, 1, 0, 64'h8000_0000_0000_0000, 64'd3, 0, "R6 div64 msb", 0);
        run_op(4'd9, 0, 0, 64'h1111_0000_FFFF_FFF0, 64'd10, 0, "R6 mod32", 0);
        // R7 / R8 zero divisor
        run_op(4'd3, 1, 0, 64'h1234_5678_9ABC_DEF0, 64'd0, 0, "R7 div64 by zero", 0);
        run_op(4'd3, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_0000_0000, 0, "R7 div32 by zero", 0);
        run_op(4'd9, 1, 0, 64'h1234_5678_9ABC_DEF0, 64'd0, 0, "R8 mod64 by zero", 0);
        run_op(4'd9, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'd0, 0, "R8 mod32 by zero", 0);
        // R10 start while busy ignored
        run_op(4'd3, 1, 0, 64'd1000, 64'd9, 0, "R10 div64 poke", 1);
        run_op(4'd9, 0, 0, 64'd1000, 64'd9, 0, "R10 mod32 poke", 1);
        // R11 undefined codes
        run_op(4'd13, 1, 0, 64'd5, 64'd6, 0, "R11 code13", 0);
        run_op(4'd15, 0, 0, 64'd5, 64'd6, 0, "R11 code15", 0);

        seed_sink = $urandom(32'h5EED_0042);
        for (int i = 0; i < 300; i++) begin
            logic [3:0]  ro;
            logic [63:0] rd, rs;
            ro = 4'($urandom_range(0, 15));
            rd = {$urandom, $urandom};
            rs = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) rs = 64'($urandom_range(0, 70));
            if ($urandom_range(0, 9) == 0) rs = 64'd0;
            run_op(ro, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rd, rs, $urandom,
                   "R1 R3 R4 R5 R6 R11 random", 0);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule